// File: doc/BRIEF.md
# Five-Channel Output-Compare Unit with Deferred Forcing

This block watches a 16-bit free-running counter that advances by one on every clock edge where the count-enable tick is high. Five compare channels each hold a value. When the counter steps onto a channel's value, the channel performs its programmed pin action and raises its status flag. Channels two to five each own one port pin and take a 2-bit action code. Channel one can drive any of the five pins at once. A mask register picks the pins it drives, and a data register gives the values they take.

Software can fire any channel early through a write-only force register. A force write arms a per-channel request. The request waits for the next counter tick, then performs the channel's pin action and disarms. A forced action never raises a status flag. Each request is a two-state machine per channel. `ARM_IDLE` goes to `ARM_PENDING` on a force write. `ARM_PENDING` goes back to `ARM_IDLE` on a tick, unless a new force write arrives in the same cycle, in which case it stays in `ARM_PENDING`.

Register map on the 4-bit address:
- 0: counter (read only)
- 1 to 5: compare values for channels 1 to 5
- 6: action codes
- 7: force
- 8: channel-1 mask
- 9: channel-1 data
- 10: flags

Top module: `oc_unit`

## Requirements
- R1: Reset clears the counter to 0. Each clock edge with `tick` high adds one to it, wrapping modulo 2^16. Without `tick` the counter holds. It reads back at address 0.
- R2: On the clock edge where the counter steps onto a channel's compare value, that channel's flag is set. Channel k's flag appears at flag-register bit 8-k (channel 1 at bit 7, channel 5 at bit 3) and on `irq_flags[5-k]`.
- R3: Channels 2 to 5 drive pins 6, 5, 4 and 3 on `pin_out[3:0]`, where `pin_out[n]` is pin n+3. Their action fields sit at address 6: channel 2 at [7:6], channel 3 at [5:4], channel 4 at [3:2] and channel 5 at [1:0]. The codes are 00 no change, 01 toggle, 10 drive 0 and 11 drive 1.
- R4: On a channel-1 event, each pin whose mask bit is set (address 8, bit n+3 for `pin_out[n]`) takes the matching bit of the data register (address 9). Pins with a clear mask bit are left as they were.
- R5: If channel 1 and another channel act on the same pin at the same edge, the pin takes channel 1's value.
- R6: Writing 1 to force bit 8-k (address 7) arms channel k. Its pin action happens at the first tick edge after the write, never before. The request then clears, so later ticks repeat nothing.
- R7: A forced action never sets a flag.
- R8: The force register always reads 0. Bits 2 to 0 of the mask register read 0. Mask, data, action, flags and pins all reset to 0.
- R9: Writing 1 to a flag bit at address 10 clears that flag. Writing 0 leaves it set.
- R10: A toggle channel that both matches and is forced on adjacent ticks, in either order, toggles twice. Its pin ends where it started.
- R11: A force bit written as 0 leaves its channel untouched, even when other bits in the same write are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_out | output | 5 | Port pins 7..3 (`pin_out[n]` is pin n+3) |
| irq_flags | output | 5 | Status flags, bit n for channel 5-n |

## Verification
The overlap that matters is a genuine compare match and a pending force on the same channel at the same tick, or on neighbouring ticks. The bench arms a toggle channel through the force register, then places its compare value one tick before or one tick after the tick that consumes the request. It checks the pin after each tick: it must flip at both ticks and end where it started, and only the match may raise the flag. A second overlap is channel 1 and channel 2 matching on the same edge with opposing values for pin 6. The judgement there is that channel 1's data bit wins.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int unsigned OC_NCH  = 5;
    localparam int unsigned OC_REGW = 8;
    localparam int unsigned OC_LSB  = OC_REGW - OC_NCH;
    localparam int unsigned OC_AW   = 4;

    localparam logic [OC_AW-1:0] ADR_COUNT    = 4'd0;
    localparam logic [OC_AW-1:0] ADR_CMP_BASE = 4'd1;
    localparam logic [OC_AW-1:0] ADR_ACTION   = 4'd6;
    localparam logic [OC_AW-1:0] ADR_FORCE    = 4'd7;
    localparam logic [OC_AW-1:0] ADR_MASK     = 4'd8;
    localparam logic [OC_AW-1:0] ADR_DATA     = 4'd9;
    localparam logic [OC_AW-1:0] ADR_FLAGS    = 4'd10;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } oc_act_e;

    typedef enum logic {
        ARM_IDLE    = 1'b0,
        ARM_PENDING = 1'b1
    } oc_arm_e;

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next
);

    assign cnt_next = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] cnt_next,
    input  logic         force_set,
    output logic         event_o,
    output logic         match_o
);

    oc_arm_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                if (force_set) begin
                    state_d = ARM_PENDING;
                end
            end
            ARM_PENDING: begin
                if (tick && !force_set) begin
                    state_d = ARM_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        match_o = tick && (cnt_next == cmp_val);
        event_o = match_o || (tick && (state_q == ARM_PENDING));
    end

endmodule

// File: rtl/oc_pinmux.sv
module oc_pinmux
    import oc_pkg::*;
#(
    parameter int unsigned NCH = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         ev,
    input  logic [2*(NCH-1)-1:0]   act,
    input  logic [NCH-1:0]         mask,
    input  logic [NCH-1:0]         data,
    output logic [NCH-1:0]         pins_q
);

    localparam int unsigned MASTER = NCH - 1;

    logic [1:0]     act_full [NCH];
    logic [NCH-1:0] pins_d;

    for (genvar j = 0; j < NCH; j++) begin : g_act
        if (j < MASTER) begin : g_own
            assign act_full[j] = act[2*j +: 2];
        end else begin : g_master
            assign act_full[j] = ACT_NONE;
        end
    end

    always_comb begin
        for (int j = 0; j < NCH; j++) begin
            pins_d[j] = pins_q[j];
            if (ev[j]) begin
                unique case (oc_act_e'(act_full[j]))
                    ACT_NONE:   pins_d[j] = pins_q[j];
                    ACT_TOGGLE: pins_d[j] = ~pins_q[j];
                    ACT_LOW:    pins_d[j] = 1'b0;
                    ACT_HIGH:   pins_d[j] = 1'b1;
                endcase
            end
            if (ev[MASTER] && mask[j]) begin
                pins_d[j] = data[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [OC_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [OC_NCH-1:0] pin_out,
    output logic [OC_NCH-1:0] irq_flags
);

    localparam int unsigned NCH  = OC_NCH;
    localparam int unsigned ACTW = 2 * (NCH - 1);

    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic [CNT_W-1:0] cmp_q [NCH];
    logic [ACTW-1:0]  act_q;
    logic [NCH-1:0]   mask_q, data_q, flags_q;
    logic [NCH-1:0]   force_wr, flag_clr, ev, match;

    function automatic logic [OC_AW-1:0] cmp_addr(input int unsigned j);
        return ADR_CMP_BASE + OC_AW'(NCH - 1 - j);
    endfunction

    oc_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next)
    );

    assign force_wr = (bus_we && bus_addr == ADR_FORCE) ? bus_wdata[OC_LSB +: NCH] : '0;
    assign flag_clr = (bus_we && bus_addr == ADR_FLAGS) ? bus_wdata[OC_LSB +: NCH] : '0;

    for (genvar j = 0; j < NCH; j++) begin : g_ch
        oc_channel #(.W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cmp_val   (cmp_q[j]),
            .cnt_next  (cnt_next),
            .force_set (force_wr[j]),
            .event_o   (ev[j]),
            .match_o   (match[j])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NCH; j++) begin
                cmp_q[j] <= '0;
            end
            act_q   <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            for (int j = 0; j < NCH; j++) begin
                if (bus_we && bus_addr == cmp_addr(j)) begin
                    cmp_q[j] <= bus_wdata[CNT_W-1:0];
                end
            end
            if (bus_we && bus_addr == ADR_ACTION) begin
                act_q <= bus_wdata[ACTW-1:0];
            end
            if (bus_we && bus_addr == ADR_MASK) begin
                mask_q <= bus_wdata[OC_LSB +: NCH];
            end
            if (bus_we && bus_addr == ADR_DATA) begin
                data_q <= bus_wdata[OC_LSB +: NCH];
            end
            flags_q <= (flags_q & ~flag_clr) | match;
        end
    end

    oc_pinmux #(.NCH(NCH)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .act    (act_q),
        .mask   (mask_q),
        .data   (data_q),
        .pins_q (pin_out)
    );

    assign irq_flags = flags_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_COUNT:  bus_rdata = DATA_W'(cnt_q);
            ADR_ACTION: bus_rdata = DATA_W'(act_q);
            ADR_FORCE:  bus_rdata = '0;
            ADR_MASK:   bus_rdata = DATA_W'({mask_q, OC_LSB'(0)});
            ADR_DATA:   bus_rdata = DATA_W'({data_q, OC_LSB'(0)});
            ADR_FLAGS:  bus_rdata = DATA_W'({flags_q, OC_LSB'(0)});
            default: begin
                for (int j = 0; j < NCH; j++) begin
                    if (bus_addr == cmp_addr(j)) begin
                        bus_rdata = DATA_W'(cmp_q[j]);
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk
    import oc_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_we,
    input logic [OC_AW-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [OC_NCH-1:0] pin_out,
    input logic [OC_NCH-1:0] irq_flags
);

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + 1'b1);

    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    a_r6_pins_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin_out));

    a_r2_flags_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (irq_flags & ~$past(irq_flags)) == '0);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_FLAGS && !tick) |=>
            (irq_flags & $past(bus_wdata[OC_LSB +: OC_NCH])) == '0);

    a_r8_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_FORCE) |-> bus_rdata == '0);

endmodule

bind oc_unit oc_unit_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_q),
    .pin_out   (pin_out),
    .irq_flags (irq_flags)
);

// File: tb/test_oc_unit.sv
module test_oc_unit;
    import oc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  pin_out, irq_flags;

    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    int unsigned cnt_m = 0;
    logic [4:0]  pin_m = '0;
    logic [7:0]  act_m = '0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    oc_unit i_oc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .irq_flags (irq_flags)
    );

    // {channel number, action code}
    localparam logic [4:0] VEC [8] = '{
        {3'd2, 2'b11}, {3'd3, 2'b01}, {3'd4, 2'b11}, {3'd5, 2'b01},
        {3'd2, 2'b10}, {3'd3, 2'b00}, {3'd4, 2'b01}, {3'd5, 2'b10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            cnt_m++;
        end
    endtask

    function automatic logic apply(input logic [1:0] a, input logic p);
        case (a)
            2'b01:   return ~p;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return p;
        endcase
    endfunction

    function automatic logic [15:0] cmp_adr(input int k);
        return 16'(k);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 / R1: reset state
        chk("R8 pins reset", pin_out, 0);
        chk("R8 flags reset", irq_flags, 0);
        rd(ADR_COUNT, rv); chk("R1 counter reset", rv, 0);
        rd(ADR_MASK, rv);  chk("R8 mask reset", rv, 0);

        // Vector table: channels 2..5 compare actions (R2, R3)
        for (int i = 0; i < 8; i++) begin
            int k = int'(VEC[i][4:2]);
            int j = 5 - k;
            act_m[2*j +: 2] = VEC[i][1:0];
            wr(ADR_ACTION, 16'(act_m));
            wr(4'(k), 16'(cnt_m + 2));
            step(1);
            chk("R3 no action before match", pin_out, pin_m);
            chk("R2 no flag before match", irq_flags[j], 0);
            step(1);
            pin_m[j] = apply(VEC[i][1:0], pin_m[j]);
            chk("R3 action on match", pin_out, pin_m);
            chk("R2 flag on match", irq_flags[j], 1);
            wr(ADR_FLAGS, 16'(1 << (j + 3)));
            chk("R9 flag cleared", irq_flags, 0);
        end
        rd(ADR_COUNT, rv); chk("R1 counter advances", rv, 16'(cnt_m));

        // R8: mask low bits read zero; force reads zero
        wr(ADR_MASK, 16'h00FF);
        rd(ADR_MASK, rv); chk("R8 mask low bits", rv, 16'h00F8);
        rd(ADR_FORCE, rv); chk("R8 force reads 0", rv, 0);

        // R4: channel 1 masked group
        wr(ADR_MASK, 16'h00A8);
        wr(ADR_DATA, 16'h00FF);
        wr(4'd1, 16'(cnt_m + 1));
        step(1);
        pin_m[4] = 1'b1; pin_m[2] = 1'b1; pin_m[0] = 1'b1;
        chk("R4 masked pins take data", pin_out, pin_m);
        chk("R2 channel 1 flag", irq_flags[4], 1);
        wr(ADR_FLAGS, 16'h0080);

        // R5: channel 1 beats channel 2 on pin 6
        act_m[7:6] = 2'b10;
        wr(ADR_ACTION, 16'(act_m));
        wr(ADR_MASK, 16'h0040);
        wr(ADR_DATA, 16'h0040);
        wr(4'd1, 16'(cnt_m + 1));
        wr(4'd2, 16'(cnt_m + 1));
        step(1);
        pin_m[3] = 1'b1;
        chk("R5 channel 1 priority", pin_out, pin_m);

        // R9: write 0 keeps flag, write 1 clears
        wr(ADR_FLAGS, 16'h0000);
        chk("R9 zero write keeps flags", irq_flags, 5'b11000);
        wr(ADR_FLAGS, 16'h0040);
        chk("R9 one write clears ch2 only", irq_flags, 5'b10000);
        wr(ADR_FLAGS, 16'h0080);

        // R6 / R7: deferred force on channel 3 (drive low)
        act_m[5:4] = 2'b10;
        wr(ADR_ACTION, 16'(act_m));
        wr(ADR_FORCE, 16'h0020);
        repeat (3) @(negedge clk);
        chk("R6 no action before tick", pin_out, pin_m);
        step(1);
        pin_m[2] = 1'b0;
        chk("R6 forced action at tick", pin_out, pin_m);
        chk("R7 force leaves flags", irq_flags, 0);

        // R11: force only channel 4, channel 5 toggle stays put
        act_m[3:2] = 2'b11; act_m[1:0] = 2'b01;
        wr(ADR_ACTION, 16'(act_m));
        wr(ADR_FORCE, 16'h0010);
        step(1);
        pin_m[1] = 1'b1;
        chk("R11 unforced channel untouched", pin_out, pin_m);
        step(1);
        chk("R6 request consumed once", pin_out, pin_m);

        // R10: match then force on toggle channel 4
        act_m[3:2] = 2'b01;
        wr(ADR_ACTION, 16'(act_m));
        wr(4'd4, 16'(cnt_m + 1));
        step(1);
        pin_m[1] = ~pin_m[1];
        chk("R10 first toggle (match)", pin_out, pin_m);
        wr(ADR_FORCE, 16'h0010);
        step(1);
        pin_m[1] = ~pin_m[1];
        chk("R10 second toggle (force)", pin_out, pin_m);
        chk("R10 pin back at start", pin_out[1], 1);
        wr(ADR_FLAGS, 16'h0010);

        // R10: force then match
        wr(ADR_FORCE, 16'h0010);
        wr(4'd4, 16'(cnt_m + 2));
        step(1);
        pin_m[1] = ~pin_m[1];
        chk("R10 first toggle (force)", pin_out, pin_m);
        chk("R7 no flag from force", irq_flags[1], 0);
        step(1);
        pin_m[1] = ~pin_m[1];
        chk("R10 second toggle (match)", pin_out, pin_m);
        chk("R2 flag from match", irq_flags[1], 1);

        rd(ADR_COUNT, rv); chk("R1 counter final", rv, 16'(cnt_m));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule